// File: doc/BRIEF.md
# Modulo 2^m-1 Exponent Combiner

This block combines the exponents of two nonzero field elements of GF(2^m), written in power form against a primitive element, into the exponent of their product or quotient. The exponents live in the range 0 to 2^m-2 and combine modulo 2^m-1 (modulo 15 for the default m = 4). A per-operation select bit picks multiplication, which adds the exponents, or division, which adds the bitwise inverse of the divisor exponent. That inverse equals 2^m-1 minus the exponent, so division needs no subtractor. The wrap back into range is a single conditional increment, not a general modulo reduction.

Each operand comes with a recognition bit that says it was identified as a nonzero element. The result carries a valid flag: the AND of the two recognition bits. When that flag is low, an operand was zero and the exponent output carries no meaning. Downstream logic is then responsible for producing the zero element. The unit is a two-stage pipeline: it accepts a new operation on every clock, and each result appears exactly two clock edges after its operands.

Top module: `gfx_expo_combiner`

## Requirements
- R1: While the asynchronous active-low reset is asserted, rp reads 0 and rr reads 0. Both take these values immediately when reset asserts, including in the middle of a stream.
- R2: A result appears on rp/rr exactly two rising clock edges after its inputs are sampled. A new operation is accepted on every edge, and operations with different op values may follow each other back to back.
- R3: With op = 0 (multiply) and exponents px, py in 0..14, rp = (px + py) mod 15.
- R4: With op = 1 (divide) and exponents px, py in 0..14, rp = (px - py) mod 15, which always lies in 0..14.
- R5: An exponent sum of exactly 15 wraps to 0, and the largest multiply sum, 14 + 14 = 28, wraps to 13. The 4-bit adder carry-out takes part in the wrap decision.
- R6: Dividing by exponent 0 (op = 1, py = 0, whose inverse is 1111) returns px unchanged.
- R7: rr = rx AND ry for the same operation, with the same two-cycle latency as rp, whatever the value of op.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| px | input | EXP_W | Exponent of the first operand (multiplicand or dividend) |
| py | input | EXP_W | Exponent of the second operand (multiplier or divisor) |
| rx | input | 1 | First operand recognised as nonzero |
| ry | input | 1 | Second operand recognised as nonzero |
| op | input | 1 | 0 = multiply (add exponents), 1 = divide (subtract exponents) |
| rp | output | EXP_W | Exponent of the result, modulo 2^EXP_W-1 |
| rr | output | 1 | Result valid: both operands were nonzero |

## Verification
Both rp and rr of an operation are due two rising edges after the edge that samples its inputs. The bench drives a new operation on every falling edge. On the same falling edge it compares the outputs against the operation driven two falling edges earlier, so a result that arrives one cycle early or late shows up as a mismatch. Reset is checked at a falling edge while reset is held, and again just after an asynchronous assertion in the middle of a stream, before any clock edge can intervene.

// File: rtl/gfx_pkg.sv
package gfx_pkg;

  typedef enum logic {
    GFX_OP_MUL = 1'b0,
    GFX_OP_DIV = 1'b1
  } gfx_op_e;

  // Largest legal exponent for an m-bit field: 2^m - 2
  function automatic int gfx_max_exp(input int w);
    return (1 << w) - 2;
  endfunction

endpackage

// File: rtl/gfx_opnd_cond.sv
// Conditions the second operand: passes it for multiply, inverts every bit for divide.
module gfx_opnd_cond #(
  parameter int EXP_W = 4
) (
  input  logic             op,
  input  logic [EXP_W-1:0] py,
  output logic [EXP_W-1:0] py_eff
);

  genvar gi;
  generate
    for (gi = 0; gi < EXP_W; gi++) begin : g_bit
      assign py_eff[gi] = py[gi] ^ op;
    end
  endgenerate

endmodule

// File: rtl/gfx_wrap_fix.sv
// Folds an (EXP_W+1)-bit exponent sum back into 0 .. 2^EXP_W-2.
module gfx_wrap_fix #(
  parameter int EXP_W = 4
) (
  input  logic [EXP_W:0]   sum,
  output logic [EXP_W-1:0] res
);

  localparam int          MAX_EXP = gfx_pkg::gfx_max_exp(EXP_W);
  localparam logic [EXP_W:0] MAX_V = (EXP_W + 1)'(MAX_EXP);

  logic over;

  always_comb begin
    over = (sum > MAX_V);
    if (over) res = sum[EXP_W-1:0] + EXP_W'(1);
    else      res = sum[EXP_W-1:0];
  end

endmodule

// File: rtl/gfx_stage_reg.sv
// Pipeline register with async active-low reset and explicit clock enable.
module gfx_stage_reg #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [DW-1:0] d,
  output logic [DW-1:0] q
);

  logic [DW-1:0] q_nxt;

  always_comb begin
    q_nxt = q;
    if (en) q_nxt = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end

endmodule

// File: rtl/gfx_expo_combiner.sv
module gfx_expo_combiner #(
  parameter int EXP_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [EXP_W-1:0] px,
  input  logic [EXP_W-1:0] py,
  input  logic             rx,
  input  logic             ry,
  input  logic             op,
  output logic [EXP_W-1:0] rp,
  output logic             rr
);

  localparam int SUM_W = EXP_W + 1;
  localparam int S1_W  = SUM_W + 1;
  localparam int S2_W  = EXP_W + 1;

  logic             pipe_en;
  logic [EXP_W-1:0] py_eff;
  logic [SUM_W-1:0] s1_sum_d;
  logic             s1_vld_d;
  logic [S1_W-1:0]  s1_d;
  logic [S1_W-1:0]  s1_q;
  logic [SUM_W-1:0] s1_sum_q;
  logic             s1_vld_q;
  logic [EXP_W-1:0] s2_exp_d;
  logic [S2_W-1:0]  s2_d;
  logic [S2_W-1:0]  s2_q;

  assign pipe_en = 1'b1;

  // Stage 1: operand conditioning and addition
  gfx_opnd_cond #(.EXP_W(EXP_W)) u_cond (
    .op     (op),
    .py     (py),
    .py_eff (py_eff)
  );

  always_comb begin
    s1_sum_d = {1'b0, px} + {1'b0, py_eff};
    s1_vld_d = rx & ry;
    s1_d     = {s1_vld_d, s1_sum_d};
  end

  gfx_stage_reg #(.DW(S1_W)) u_s1 (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (pipe_en),
    .d     (s1_d),
    .q     (s1_q)
  );

  assign s1_sum_q = s1_q[SUM_W-1:0];
  assign s1_vld_q = s1_q[S1_W-1];

  // Stage 2: end-around wrap into range
  gfx_wrap_fix #(.EXP_W(EXP_W)) u_wrap (
    .sum (s1_sum_q),
    .res (s2_exp_d)
  );

  assign s2_d = {s1_vld_q, s2_exp_d};

  gfx_stage_reg #(.DW(S2_W)) u_s2 (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (pipe_en),
    .d     (s2_d),
    .q     (s2_q)
  );

  assign rp = s2_q[EXP_W-1:0];
  assign rr = s2_q[EXP_W];

endmodule

// File: rtl/gfx_expo_combiner_chk.sv
module gfx_expo_combiner_chk #(
  parameter int EXP_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [EXP_W-1:0] px,
  input logic [EXP_W-1:0] py,
  input logic             rx,
  input logic             ry,
  input logic             op,
  input logic [EXP_W-1:0] rp,
  input logic             rr
);

  localparam int MODV = (1 << EXP_W) - 1;

  logic [1:0] warm_cnt;
  logic       warm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              warm_cnt <= 2'd0;
    else if (warm_cnt != 2'd2) warm_cnt <= warm_cnt + 2'd1;
  end

  assign warm = (warm_cnt == 2'd2);

  // R1
  always @(posedge clk) begin
    if (rst_n == 1'b0) begin
      reset_clear_chk: assert (rp == '0 && rr == 1'b0);
    end
  end

  // R7
  valid_and_chk: assert property (@(posedge clk) disable iff (!rst_n)
    warm |-> (rr == ($past(rx, 2) && $past(ry, 2))));

  // R3
  mul_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && !$past(op, 2) && int'($past(px, 2)) < MODV && int'($past(py, 2)) < MODV)
    |-> (int'(rp) == (int'($past(px, 2)) + int'($past(py, 2))) % MODV));

  // R4
  div_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && $past(op, 2) && int'($past(px, 2)) < MODV && int'($past(py, 2)) < MODV)
    |-> (int'(rp) == (int'($past(px, 2)) + MODV - int'($past(py, 2))) % MODV));

  // R5
  range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && int'($past(px, 2)) < MODV && int'($past(py, 2)) < MODV)
    |-> (int'(rp) < MODV));

endmodule

bind gfx_expo_combiner gfx_expo_combiner_chk #(.EXP_W(EXP_W)) u_chk (.*);

// File: tb/gfx_expo_combiner_test.sv
module gfx_expo_combiner_test;

  localparam int W    = 4;
  localparam int MODV = 15;
  localparam int NVEC = 450;

  logic         clk;
  logic         rst_n;
  logic [W-1:0] px;
  logic [W-1:0] py;
  logic         rx;
  logic         ry;
  logic         op;
  logic [W-1:0] rp;
  logic         rr;

  int    n_checks;
  int    n_fails;
  bit    done;
  int    exp_rp [0:511];
  bit    exp_rr [0:511];
  string exp_tag [0:511];

  gfx_expo_combiner #(.EXP_W(W)) uut (
    .clk (clk), .rst_n (rst_n), .px (px), .py (py),
    .rx (rx), .ry (ry), .op (op), .rp (rp), .rr (rr)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string tag, input int got, input int expv);
    n_checks++;
    if (got != expv) begin
      n_fails++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, got, expv, $time);
    end
  endtask

  task automatic drive(input int idx);
    int a, b, o;
    bit vx, vy;
    o  = idx / 225;
    a  = (idx % 225) / 15;
    b  = idx % 15;
    vx = (idx % 3) != 0;
    vy = (idx % 5) != 1;
    px = W'(a); py = W'(b); op = o[0]; rx = vx; ry = vy;
    exp_rr[idx] = vx & vy;
    if (o == 0) begin
      exp_rp[idx] = (a + b) % MODV;
      if (a + b == 15 || a + b == 28) exp_tag[idx] = "R2 R3 R5";
      else                            exp_tag[idx] = "R2 R3";
    end else begin
      exp_rp[idx] = (a - b + MODV) % MODV;
      if (b == 0) exp_tag[idx] = "R2 R4 R6";
      else        exp_tag[idx] = "R2 R4";
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
  endtask

  initial begin
    n_checks = 0; n_fails = 0; done = 1'b0;
    rst_n = 1'b0; px = '0; py = '0; rx = 1'b0; ry = 1'b0; op = 1'b0;
    repeat (3) @(negedge clk);
    // R1: outputs clear while reset held
    check("R1 rp in reset", int'(rp), 0);
    check("R1 rr in reset", int'(rr), 0);
    rst_n = 1'b1;

    // R2..R7: full sweep, one operation per cycle, result due two edges later
    for (int i = 0; i < NVEC + 2; i++) begin
      @(negedge clk);
      if (i >= 2) begin
        check({exp_tag[i-2], " rp"}, int'(rp), exp_rp[i-2]);
        check("R7 rr", int'(rr), int'(exp_rr[i-2]));
      end
      if (i < NVEC) drive(i);
      else begin px = '0; py = '0; rx = 1'b0; ry = 1'b0; op = 1'b0; end
    end

    // R5 directed: 7 + 8 wraps to 0
    px = 4'd7; py = 4'd8; op = 1'b0; rx = 1'b1; ry = 1'b1;
    @(negedge clk);
    px = 4'd9; py = 4'd0; op = 1'b1;
    @(negedge clk);
    check("R5 sum 15 to 0", int'(rp), 0);
    @(negedge clk);
    check("R6 divide by exponent 0", int'(rp), 9);
    check("R7 rr both set", int'(rr), 1);

    // R1: asynchronous reset mid-stream
    px = 4'd14; py = 4'd14; op = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R5 sum 28 to 13", int'(rp), 13);
    #3 rst_n = 1'b0;
    #1;
    check("R1 rp async clear", int'(rp), 0);
    check("R1 rr async clear", int'(rr), 0);
    @(negedge clk);
    rst_n = 1'b1;

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

endmodule